// File: doc/BRIEF.md
# Press-and-Hold Volume Step Controller

This block holds the volume setting of a two-channel power amplifier as a 5-bit step number. Step 0 is the loudest setting and step 31 is silence. Two push buttons drive it, one for louder and one for quieter, and both are active low. A fresh press moves the setting by one step at once. If the button stays down, the block waits for a long first interval and then keeps stepping at a shorter period until the button is released.

The step number is turned into an attenuation figure in dB. The steps are 1 dB apart at the loud end, 2 dB in the middle band and 3 dB towards the quiet end. The last step gives a dedicated mute code. After reset the block loads a preset step. A sleep input freezes the setting. When sleep ends, a memory-enable input chooses between keeping the step that was held before sleep and reloading the preset.

Top module: `vol_stepper`

## Requirements
- R1: `step_idx` stays within 0 to 31. Stepping louder at 0 leaves it at 0, and stepping quieter at 31 leaves it at 31. It never wraps.
- R2: `atten_db` is a function of `step_idx` (s):
  - s for s in 0..10;
  - 2s−10 for s in 11..20;
  - 3s−30 for s in 21..30;
  - the mute code 63 for s = 31.
- R3: During reset and after it, `step_idx` equals PRESET. The default is 14, which is 18 dB of attenuation.
- R4: A press of `up_n` lowers `step_idx` by one and a press of `down_n` raises it by one. The step appears on the (DEB_LEN+3)-th rising edge, counting the first edge that samples the input low as edge 1.
- R5: While the same button stays held, the second step comes INIT_DLY cycles after the first. Every later step comes RPT_DLY cycles after the one before it.
- R6: When both buttons are held, the quieter (down) request wins. Any change of the effective request to a new direction makes an immediate step and restarts the long first interval.
- R7: Releasing a button cancels any pending repeat, and the next press starts again with an immediate step. A low pulse that lasts fewer than DEB_LEN cycles after synchronisation is ignored.
- R8: While `sleep` is high, `step_idx` does not change and button presses have no effect.
- R9: On the first cycle with `sleep` low after a sleep period, the step index is handled by `mem_en`. With `mem_en` low it reloads PRESET. With `mem_en` high it keeps the value held before sleep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_n | input | 1 | Louder button, active low, asynchronous |
| down_n | input | 1 | Quieter button, active low, asynchronous |
| sleep | input | 1 | Shutdown request, active high |
| mem_en | input | 1 | Keep the step across sleep when high |
| step_idx | output | 5 | Current volume step, 0 loudest, 31 mute |
| atten_db | output | 6 | Attenuation in dB, 63 for mute |

## Verification
The bench builds the block with INIT_DLY=40, RPT_DLY=8 and DEB_LEN=3. At these values a held button runs the index from the preset to both ends within a few hundred cycles, so saturation and the mute code are reached. The short debounce lets a two-cycle glitch be tested against the filter. The first-interval and repeat windows are short enough that a hold ending between two repeats can be placed exactly. The same values let sleep entry and exit be exercised with the memory input at both settings.

// File: rtl/vol_pkg.sv
package vol_pkg;
  localparam int VOL_IDX_W = 5;
  localparam int VOL_ATT_W = 6;
  localparam int VOL_TOP   = 31;
  localparam int VOL_MUTE  = 63;

  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_UP   = 2'd1,
    REQ_DN   = 2'd2
  } vol_req_e;

  // Piecewise attenuation: 1 dB, then 2 dB, then 3 dB per step, mute at top
  function automatic logic [VOL_ATT_W-1:0] step_to_atten(input logic [VOL_IDX_W-1:0] s);
    int si;
    int v;
    si = int'(s);
    if (si == VOL_TOP)   v = VOL_MUTE;
    else if (si <= 10)   v = si;
    else if (si <= 20)   v = 2 * si - 10;
    else                 v = 3 * si - 30;
    return VOL_ATT_W'(v);
  endfunction
endpackage

// File: rtl/vol_key_cond.sv
module vol_key_cond #(
  parameter int DEB_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_n,
  output logic held
);
  localparam int DW = (DEB_LEN < 2) ? 1 : $clog2(DEB_LEN + 1);
  localparam logic [DW-1:0] DLIM = DW'(DEB_LEN - 1);

  logic s1, s2;
  logic [DW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      held <= 1'b0;
      cnt  <= '0;
    end else begin
      s1 <= ~raw_n;
      s2 <= s1;
      if (s2 == held) begin
        cnt <= '0;
      end else if (cnt == DLIM) begin
        held <= s2;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vol_repeat_timer.sv
module vol_repeat_timer
  import vol_pkg::*;
#(
  parameter int INIT_DLY = 25000000,
  parameter int RPT_DLY  = 5000000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  vol_req_e req,
  output logic     fire,
  output logic     fire_down
);
  localparam int MAXD = (INIT_DLY > RPT_DLY) ? INIT_DLY : RPT_DLY;
  localparam int CW   = $clog2(MAXD + 1);
  localparam logic [CW-1:0] ILIM = CW'(INIT_DLY - 1);
  localparam logic [CW-1:0] RLIM = CW'(RPT_DLY - 1);

  vol_req_e      req_q;
  logic [CW-1:0] cnt;
  logic          first;
  logic          start, tick;

  always_comb begin
    start     = (req != REQ_NONE) && (req != req_q);
    tick      = (req != REQ_NONE) && !start && (cnt == (first ? ILIM : RLIM));
    fire      = start | tick;
    fire_down = (req == REQ_DN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= REQ_NONE;
      cnt   <= '0;
      first <= 1'b1;
    end else begin
      req_q <= req;
      if (fire) begin
        cnt   <= '0;
        first <= start;
      end else if (req != REQ_NONE) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt   <= '0;
        first <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vol_index_reg.sv
module vol_index_reg
  import vol_pkg::*;
#(
  parameter int PRESET = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  logic                 go_down,
  input  logic                 sleep,
  input  logic                 mem_en,
  output logic [VOL_IDX_W-1:0] idx,
  output logic                 sleep_exit
);
  localparam logic [VOL_IDX_W-1:0] PRE = VOL_IDX_W'(PRESET);
  localparam logic [VOL_IDX_W-1:0] TOP = VOL_IDX_W'(VOL_TOP);

  logic sleep_q;

  assign sleep_exit = sleep_q & ~sleep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx     <= PRE;
      sleep_q <= 1'b0;
    end else begin
      sleep_q <= sleep;
      if (sleep_exit && !mem_en) begin
        idx <= PRE;
      end else if (!sleep && fire) begin
        if (go_down && idx != TOP)     idx <= idx + 1'b1;
        else if (!go_down && idx != '0) idx <= idx - 1'b1;
      end
    end
  end
endmodule

// File: rtl/vol_stepper.sv
module vol_stepper
  import vol_pkg::*;
#(
  parameter int PRESET   = 14,
  parameter int INIT_DLY = 25000000,
  parameter int RPT_DLY  = 5000000,
  parameter int DEB_LEN  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       up_n,
  input  logic       down_n,
  input  logic       sleep,
  input  logic       mem_en,
  output logic [4:0] step_idx,
  output logic [5:0] atten_db
);
  localparam int NKEY = 2;

  logic [NKEY-1:0] raw_n;
  logic [NKEY-1:0] held;
  vol_req_e        req;
  logic            fire_w, go_down_w, sleep_exit_w;

  assign raw_n = {down_n, up_n};

  generate
    for (genvar k = 0; k < NKEY; k++) begin : g_key
      vol_key_cond #(.DEB_LEN(DEB_LEN)) u_key (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_n (raw_n[k]),
        .held  (held[k])
      );
    end
  endgenerate

  // Down (bit 1) has priority over up (bit 0); sleep masks both
  always_comb begin
    if (sleep)        req = REQ_NONE;
    else if (held[1]) req = REQ_DN;
    else if (held[0]) req = REQ_UP;
    else              req = REQ_NONE;
  end

  vol_repeat_timer #(.INIT_DLY(INIT_DLY), .RPT_DLY(RPT_DLY)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .fire      (fire_w),
    .fire_down (go_down_w)
  );

  vol_index_reg #(.PRESET(PRESET)) u_idx (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire_w),
    .go_down    (go_down_w),
    .sleep      (sleep),
    .mem_en     (mem_en),
    .idx        (step_idx),
    .sleep_exit (sleep_exit_w)
  );

  assign atten_db = step_to_atten(step_idx);
endmodule

// File: rtl/vol_stepper_chk.sv
module vol_stepper_chk #(
  parameter int PRESET = 14
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep,
  input logic       mem_en,
  input logic [4:0] step_idx,
  input logic [5:0] atten_db,
  input logic       fire_w,
  input logic       go_down_w,
  input logic       sleep_exit_w
);
  a_r1_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_w && !go_down_w && !sleep && !sleep_exit_w && step_idx == 5'd0) |=> step_idx == 5'd0);

  a_r1_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_w && go_down_w && !sleep && !sleep_exit_w && step_idx == 5'd31) |=> step_idx == 5'd31);

  a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire_w && !sleep_exit_w) |=> $stable(step_idx));

  a_r2_mute: assert property (@(posedge clk) disable iff (!rst_n)
    (step_idx == 5'd31) |-> atten_db == 6'd63);

  a_r2_no_false_mute: assert property (@(posedge clk) disable iff (!rst_n)
    (step_idx != 5'd31) |-> atten_db <= 6'd60);

  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable(step_idx));

  a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_exit_w && !mem_en) |=> step_idx == 5'(PRESET));

  a_r9_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_exit_w && mem_en && !fire_w) |=> $stable(step_idx));
endmodule

bind vol_stepper vol_stepper_chk #(.PRESET(PRESET)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sleep        (sleep),
  .mem_en       (mem_en),
  .step_idx     (step_idx),
  .atten_db     (atten_db),
  .fire_w       (fire_w),
  .go_down_w    (go_down_w),
  .sleep_exit_w (sleep_exit_w)
);

// File: tb/vol_stepper_bench.sv
`timescale 1ns/1ps
module vol_stepper_bench;
  localparam int PRE  = 14;
  localparam int INIT = 40;
  localparam int RPT  = 8;
  localparam int DEB  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_n = 1'b1, down_n = 1'b1, sleep = 1'b0, mem_en = 1'b0;
  logic [4:0] step_idx;
  logic [5:0] atten_db;

  int vectors = 0, miscompares = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vol_stepper #(.PRESET(PRE), .INIT_DLY(INIT), .RPT_DLY(RPT), .DEB_LEN(DEB)) u_vol_stepper (
    .clk(clk), .rst_n(rst_n), .up_n(up_n), .down_n(down_n),
    .sleep(sleep), .mem_en(mem_en), .step_idx(step_idx), .atten_db(atten_db)
  );

  // Attenuation by summing per-step increments
  function automatic int ref_atten(int s);
    int a = 0;
    if (s == 31) return 63;
    for (int i = 1; i <= s; i++) a += (i <= 10) ? 1 : ((i <= 20) ? 2 : 3);
    return a;
  endfunction

  // Behavioural reference state (0 = up key, 1 = down key)
  int m_s1[2], m_s2[2], m_h[2], m_dc[2];
  int m_rq, m_cnt, m_first, m_idx, m_slq;

  task automatic model_reset();
    for (int k = 0; k < 2; k++) begin m_s1[k] = 0; m_s2[k] = 0; m_h[k] = 0; m_dc[k] = 0; end
    m_rq = 0; m_cnt = 0; m_first = 1; m_idx = PRE; m_slq = 0;
  endtask

  always @(posedge clk) begin
    int rq, go, tk, fr, nidx;
    int raw[2];
    cyc++;
    if (!rst_n) model_reset();
    else begin
      raw[0] = !up_n; raw[1] = !down_n;
      rq = sleep ? 0 : (m_h[1] ? 2 : (m_h[0] ? 1 : 0));
      go = (rq != 0 && rq != m_rq);
      tk = (rq != 0 && !go && m_cnt == (m_first ? INIT - 1 : RPT - 1));
      fr = go || tk;
      nidx = m_idx;
      if (m_slq && !sleep && !mem_en) nidx = PRE;
      else if (!sleep && fr) begin
        if (rq == 2 && m_idx < 31) nidx = m_idx + 1;
        if (rq == 1 && m_idx > 0)  nidx = m_idx - 1;
      end
      m_idx = nidx;
      if (fr) begin m_cnt = 0; m_first = go; end
      else if (rq != 0) m_cnt++;
      else begin m_cnt = 0; m_first = 1; end
      m_rq = rq;
      for (int k = 0; k < 2; k++) begin
        if (m_s2[k] == m_h[k]) m_dc[k] = 0;
        else if (m_dc[k] == DEB - 1) begin m_h[k] = m_s2[k]; m_dc[k] = 0; end
        else m_dc[k]++;
        m_s2[k] = m_s1[k];
        m_s1[k] = raw[k];
      end
      m_slq = sleep;
    end
  end

  // Every-cycle comparison against the reference (R1 index, R2 attenuation)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      if (int'(step_idx) != m_idx || int'(atten_db) != ref_atten(m_idx)) begin
        miscompares++;
        $display("FAIL R1/R2 cycle %0d: idx=%0d att=%0d expected idx=%0d att=%0d",
                 cyc, step_idx, atten_db, m_idx, ref_atten(m_idx));
      end
    end
  end

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    miscompares++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    finish_run();
  end

  initial begin
    wait_n(3);
    check("R3 reset idx", int'(step_idx), PRE);
    check("R3 reset atten", int'(atten_db), 18);
    @(negedge clk) rst_n = 1'b1;
    wait_n(4);
    check("R3 preset after reset", int'(step_idx), PRE);

    // R7: glitch shorter than the debounce window is ignored
    down_n = 1'b0; wait_n(DEB - 1); down_n = 1'b1; wait_n(20);
    check("R7 glitch ignored", int'(step_idx), PRE);

    // R4: exact latency of an immediate step
    up_n = 1'b0;
    wait_n(DEB + 2);
    check("R4 not yet stepped", int'(step_idx), PRE);
    wait_n(1);
    check("R4 up step lands", int'(step_idx), PRE - 1);
    wait_n(5); up_n = 1'b1; wait_n(20);
    check("R4 single step for short press", int'(step_idx), 13);

    // R7: release before repeat, then a new press steps at once
    up_n = 1'b0; wait_n(30); up_n = 1'b1; wait_n(15);
    check("R7 cancelled repeat", int'(step_idx), 12);
    up_n = 1'b0; wait_n(10); up_n = 1'b1; wait_n(15);
    check("R7 restart immediate", int'(step_idx), 11);

    // R5: hold giving first step, one long interval, one repeat
    down_n = 1'b0; wait_n(INIT + RPT + 5); down_n = 1'b1; wait_n(20);
    check("R5 three steps from hold", int'(step_idx), 14);
    check("R2 atten at 14", int'(atten_db), 18);

    // R6: both held, down wins
    up_n = 1'b0; down_n = 1'b0; wait_n(10); up_n = 1'b1; down_n = 1'b1; wait_n(15);
    check("R6 down over up", int'(step_idx), 15);
    // R6: down added while up held makes an immediate down step
    up_n = 1'b0; wait_n(12); down_n = 1'b0; wait_n(10);
    down_n = 1'b1; up_n = 1'b1; wait_n(20);
    check("R6 new direction steps", int'(step_idx), 15);

    // R8: sleep freezes and ignores keys; R9 keep with mem_en high
    mem_en = 1'b1; sleep = 1'b1; wait_n(3);
    down_n = 1'b0; wait_n(60); down_n = 1'b1; wait_n(10);
    check("R8 frozen in sleep", int'(step_idx), 15);
    sleep = 1'b0; wait_n(5);
    check("R9 kept with mem_en", int'(step_idx), 15);
    down_n = 1'b0; wait_n(8); down_n = 1'b1; wait_n(15);
    check("R9 step after wake", int'(step_idx), 16);
    mem_en = 1'b0; sleep = 1'b1; wait_n(10); sleep = 1'b0; wait_n(3);
    check("R9 preset reload", int'(step_idx), PRE);

    // R1/R2: run to both ends
    down_n = 1'b0; wait_n(400); down_n = 1'b1; wait_n(15);
    check("R1 saturate top", int'(step_idx), 31);
    check("R2 mute code", int'(atten_db), 63);
    up_n = 1'b0; wait_n(500); up_n = 1'b1; wait_n(15);
    check("R1 saturate bottom", int'(step_idx), 0);
    check("R2 atten at 0", int'(atten_db), 0);
    finish_run();
  end
endmodule